// File: doc/BRIEF.md
# Vectored Level-Interrupt Controller

This block collects a set of level-sensitive interrupt lines (96 by default, grouped in banks of 32). It filters them through a per-line mask and a per-line priority, and reports to one processor which line to service first. Software reaches it through a plain 32-bit register port. The address is a byte offset whose two low bits are ignored. Writes take effect at the clock edge where `reg_wr_i` is high. A read is requested with `reg_rd_i`, and its data appears on `reg_rdata_o` one cycle later. Reads never change state.

When no result is held, the controller picks the winning line among the eligible ones. It latches that line's number into the active-number register and holds it there until software writes the acknowledge bit. The following cycle it evaluates again. Each bank has three registers: one reports the mask, one sets mask bits and one clears them, so software never needs a read-modify-write. A soft reset, started from the configuration register, returns all programmable state to its reset values over a fixed number of cycles. A status bit reports when it has finished.

Register map (byte offsets): 0x000 version, 0x010 configuration, 0x014 status, 0x040 active number, 0x048 control, 0x04C protection, 0x050 idle, 0x068 threshold. Bank b registers sit at 0x080 + 0x20*b + {0x04 mask, 0x08 mask-clear, 0x0C mask-set, 0x18 pending}. The priority register of line n sits at 0x100 + 4*n.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After power-on reset every mask bit reads 1, every priority field reads 0, the active number reads 0, status bit 0 reads 1, the threshold reads 0xFF and `irq_o` is 0.
- R2: A write to a bank's mask-set register (offset 0x0C) sets every mask bit whose data bit is 1. A write to its mask-clear register (offset 0x08) clears every mask bit whose data bit is 1. Zero data bits leave the mask unchanged, and the mask reads back at offset 0x04.
- R3: A bank's pending register (offset 0x18) reads the bank's source lines ANDed with the inverted mask, regardless of priority or threshold.
- R4: The priority register of line n keeps a 6-bit priority in bits [7:2]. Every other bit reads 0.
- R5: A line is eligible when it is high, unmasked and passes the threshold. Among eligible lines, the smallest priority value wins, and equal values go to the lower line number. The active-number register (0x040) returns the latched winner in bits [6:0] with the upper bits zero, or 0 when nothing is held.
- R6: Once latched, the active number stays constant whatever the lines do, until a write to control (0x048) with bit 0 = 1. That write clears the held result. The next edge latches the current winner, if there is one. Reads of any register do not alter the held result.
- R7: The threshold register (0x068, bits [7:0]) admits only lines whose priority is numerically below it. The value 0xFF admits all lines.
- R8: `irq_o` goes high one cycle after some line becomes eligible and low one cycle after none is.
- R9: Writing configuration (0x010) with bit 1 = 1 starts a soft reset. While it runs, configuration bit 1 reads 1, status bit 0 reads 0 and register writes are ignored. After `RST_CYCLES` cycles the state matches R1 and status bit 0 reads 1.
- R10: Configuration bit 0 (autoidle), protection bit 0 and idle bits [1:0] store what is written and read back, with no effect on arbitration or `irq_o`.
- R11: The version register (0x000) reads the 8-bit `REVISION` parameter, with major version in [7:4] and minor version in [3:0], and zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt lines, synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after reg_rd_i |
| irq_o | output | 1 | Processor interrupt request |

## Verification
On every cycle, the assertions check four things: a held active number stays stable until acknowledge, a freshly latched number belonged to an eligible line in the previous cycle, the mask-set and mask-clear writes take effect bit for bit, and a soft-reset request raises the busy state. The ordering of the winner needs the bench's sweeps, because only a computed reference shows it. Those sweeps cover priority values, tie-break by number, masking and threshold cut-off across many line patterns. The full return of state after a soft reset is also shown only by the bench's scenarios.

// File: rtl/irqvc_pkg.sv
package irqvc_pkg;
  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_VERSION = 12'h000;
  localparam logic [AW-1:0] A_CONFIG  = 12'h010;
  localparam logic [AW-1:0] A_STATUS  = 12'h014;
  localparam logic [AW-1:0] A_ACTIVE  = 12'h040;
  localparam logic [AW-1:0] A_CONTROL = 12'h048;
  localparam logic [AW-1:0] A_PROTECT = 12'h04C;
  localparam logic [AW-1:0] A_IDLE    = 12'h050;
  localparam logic [AW-1:0] A_THRESH  = 12'h068;
  localparam logic [AW-1:0] A_BANKS   = 12'h080;
  localparam logic [AW-1:0] A_PRIO    = 12'h100;

  localparam int BANK_STRIDE = 'h20;
  localparam int OFS_MASK    = 'h04;
  localparam int OFS_CLR     = 'h08;
  localparam int OFS_SET     = 'h0C;
  localparam int OFS_PEND    = 'h18;

  function automatic logic [AW-3:0] word_of(input int byte_ofs);
    logic [AW-1:0] a;
    a = AW'(byte_ofs);
    return a[AW-1:2];
  endfunction
endpackage

// File: rtl/irqvc_reset_seq.sv
module irqvc_reset_seq #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(RST_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);  // R9
endmodule

// File: rtl/irqvc_mask_bank.sv
module irqvc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all_i,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (clr_all_i) mask_q <= '1;
    else if (set_we_i)  mask_q <= mask_q | wdata_i;
    else if (clr_we_i)  mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;
  assign pend_o = src_i & ~mask_q;

  AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we_i && !clr_all_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));  // R2
  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_we_i && !clr_all_i) |=> ((mask_q & $past(wdata_i)) == '0));  // R2
endmodule

// File: rtl/irqvc_arbiter.sv
module irqvc_arbiter #(
  parameter int N    = 96,
  parameter int PW   = 6,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  input  logic [PW-1:0] prio_i [N],
  output logic          found_o,
  output logic [ID_W-1:0] win_o
);
  logic [PW-1:0] best;

  always_comb begin
    found_o = 1'b0;
    win_o   = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!found_o || prio_i[i] < best)) begin
        found_o = 1'b1;
        win_o   = ID_W'(i);
        best    = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqvc_pkg::*;
#(
  parameter int         NUM_SRC    = 96,
  parameter int         BANK_W     = 32,
  parameter int         PRIO_W     = 6,
  parameter int         RST_CYCLES = 8,
  parameter logic [7:0] REVISION   = 8'h21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [11:0]        reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o
);
  localparam int NUM_BANKS = NUM_SRC / BANK_W;
  localparam int ID_W      = $clog2(NUM_SRC);

  logic [AW-3:0] word;
  logic          busy, wr_ok, ack, sreset_go;

  assign word      = reg_addr_i[AW-1:2];
  assign wr_ok     = reg_wr_i && !busy;
  assign ack       = wr_ok && (word == word_of(int'(A_CONTROL))) && reg_wdata_i[0];
  assign sreset_go = wr_ok && (word == word_of(int'(A_CONFIG))) && reg_wdata_i[1];

  irqvc_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start_i(sreset_go), .busy_o(busy)
  );

  // Per-bank mask storage
  logic [NUM_SRC-1:0] mask_all, pend_all;
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic set_we, clr_we;
    assign set_we = wr_ok &&
      (word == word_of(int'(A_BANKS) + b*BANK_STRIDE + OFS_SET));
    assign clr_we = wr_ok &&
      (word == word_of(int'(A_BANKS) + b*BANK_STRIDE + OFS_CLR));
    irqvc_mask_bank #(.W(BANK_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .clr_all_i(busy),
      .set_we_i(set_we), .clr_we_i(clr_we), .wdata_i(reg_wdata_i),
      .src_i(src_i[b*BANK_W +: BANK_W]),
      .mask_o(mask_all[b*BANK_W +: BANK_W]),
      .pend_o(pend_all[b*BANK_W +: BANK_W])
    );
  end

  // Control / configuration registers
  logic       autoidle_q, protect_q;
  logic [1:0] idle_q;
  logic [7:0] thresh_q;
  logic [PRIO_W-1:0] prio_q [NUM_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || busy) begin
      autoidle_q <= 1'b0;
      protect_q  <= 1'b0;
      idle_q     <= '0;
      thresh_q   <= 8'hFF;
      for (int n = 0; n < NUM_SRC; n++) prio_q[n] <= '0;
    end else if (wr_ok) begin
      if (word == word_of(int'(A_CONFIG)))  autoidle_q <= reg_wdata_i[0];
      if (word == word_of(int'(A_PROTECT))) protect_q  <= reg_wdata_i[0];
      if (word == word_of(int'(A_IDLE)))    idle_q     <= reg_wdata_i[1:0];
      if (word == word_of(int'(A_THRESH)))  thresh_q   <= reg_wdata_i[7:0];
      for (int n = 0; n < NUM_SRC; n++)
        if (word == word_of(int'(A_PRIO) + 4*n))
          prio_q[n] <= reg_wdata_i[PRIO_W+1:2];
    end
  end

  // Eligibility and arbitration
  logic [NUM_SRC-1:0] elig;
  always_comb begin
    for (int n = 0; n < NUM_SRC; n++)
      elig[n] = pend_all[n] &&
                ((thresh_q == 8'hFF) || ({{(8-PRIO_W){1'b0}}, prio_q[n]} < thresh_q));
  end

  logic            found;
  logic [ID_W-1:0] win;
  irqvc_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .ID_W(ID_W)) u_arb (
    .elig_i(elig), .prio_i(prio_q), .found_o(found), .win_o(win)
  );

  // Held active number and interrupt request
  logic            held_q, irq_q;
  logic [ID_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || busy) begin
      held_q <= 1'b0;
      act_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= found;
      if (ack) begin
        held_q <= 1'b0;
        act_q  <= '0;
      end else if (!held_q && found) begin
        held_q <= 1'b1;
        act_q  <= win;
      end
    end
  end

  assign irq_o = irq_q;

  // Read path
  logic [31:0] rd_mux, rdata_q;
  always_comb begin
    rd_mux = '0;
    if (word == word_of(int'(A_VERSION)))      rd_mux[7:0]      = REVISION;
    else if (word == word_of(int'(A_CONFIG)))  rd_mux[1:0]      = {busy, autoidle_q};
    else if (word == word_of(int'(A_STATUS)))  rd_mux[0]        = !busy;
    else if (word == word_of(int'(A_ACTIVE)))  rd_mux[ID_W-1:0] = act_q;
    else if (word == word_of(int'(A_PROTECT))) rd_mux[0]        = protect_q;
    else if (word == word_of(int'(A_IDLE)))    rd_mux[1:0]      = idle_q;
    else if (word == word_of(int'(A_THRESH)))  rd_mux[7:0]      = thresh_q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (word == word_of(int'(A_BANKS) + b*BANK_STRIDE + OFS_MASK))
        rd_mux = mask_all[b*BANK_W +: BANK_W];
      if (word == word_of(int'(A_BANKS) + b*BANK_STRIDE + OFS_PEND))
        rd_mux = pend_all[b*BANK_W +: BANK_W];
    end
    for (int n = 0; n < NUM_SRC; n++)
      if (word == word_of(int'(A_PRIO) + 4*n))
        rd_mux[PRIO_W+1:2] = prio_q[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end
  assign reg_rdata_o = rdata_q;

  // Checks kept beside the logic they guard
  logic [NUM_SRC-1:0] elig_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_d <= '0;
    else        elig_d <= elig;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !ack && !busy) |=> $stable(act_q));  // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !held_q |-> (act_q == '0));  // R6
  AST_LATCH_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> elig_d[act_q]);  // R5
  AST_ACT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_q) < NUM_SRC);  // R5
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  localparam int N   = 96;
  localparam int RST = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] mask_m;
  logic [5:0]   prio_m [N];
  logic [7:0]   thr_m;

  always #4 clk = ~clk;  // 125 MHz

  irq_vector_ctrl #(.NUM_SRC(N), .RST_CYCLES(RST), .REVISION(8'h21)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic logic [5:0] pf(input int n);
    return 6'((n * 37 + 11) % 64);
  endfunction

  function automatic logic [N-1:0] pat(input int t);
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) p[i] = (((i * (t + 3)) + t * 13) % 11) == 0;
    return p;
  endfunction

  function automatic int winner(input logic [N-1:0] s);
    int w; int best;
    w = -1; best = 64;
    for (int i = 0; i < N; i++)
      if (s[i] && !mask_m[i] && (thr_m == 8'hFF || {2'b0, prio_m[i]} < thr_m)
          && int'(prio_m[i]) < best) begin
        best = int'(prio_m[i]); w = i;
      end
    return w;
  endfunction

  task automatic set_src_ack_check(input string req, input logic [N-1:0] s);
    logic [31:0] d; int w;
    @(negedge clk); src = s;
    wreg(12'h048, 32'h1);
    @(negedge clk);
    w = winner(s);
    rreg(12'h040, d);
    check(req, d, (w < 0) ? 32'h0 : 32'(w));
    check("R8 irq_o", {31'b0, irq}, {31'b0, w >= 0});
  endtask

  logic done = 1'b0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mask_m = '1; thr_m = 8'hFF;
    for (int n = 0; n < N; n++) prio_m[n] = '0;

    // R1 / R11 reset state
    for (int b = 0; b < 3; b++) begin
      rreg(12'(12'h084 + 32 * b), d); check("R1 mask", d, 32'hFFFF_FFFF);
    end
    rreg(12'h040, d); check("R1 active", d, 0);
    rreg(12'h014, d); check("R1 status", d, 1);
    rreg(12'h068, d); check("R1 threshold", d, 32'hFF);
    rreg(12'h100 + 12'(4 * 95), d); check("R1 prio", d, 0);
    check("R1 irq_o", {31'b0, irq}, 0);
    rreg(12'h000, d); check("R11 version", d, 32'h21);

    // R4 priority registers, all lines
    for (int n = 0; n < N; n++) begin
      prio_m[n] = pf(n);
      wreg(12'(12'h100 + 4 * n), {24'hFFFFFF, pf(n), 2'b11});
    end
    for (int n = 0; n < N; n++) begin
      rreg(12'(12'h100 + 4 * n), d); check("R4 prio readback", d, {24'b0, pf(n), 2'b00});
    end

    // R2 mask set/clear sweeps
    for (int b = 0; b < 3; b++) begin
      logic [31:0] pc, ps;
      pc = 32'h5A3C_F00F ^ (32'h1111_1111 << b);
      ps = 32'h0F00_1230 << b;
      wreg(12'(12'h088 + 32 * b), pc); mask_m[b*32 +: 32] &= ~pc;
      rreg(12'(12'h084 + 32 * b), d); check("R2 mask clear", d, mask_m[b*32 +: 32]);
      wreg(12'(12'h08C + 32 * b), ps); mask_m[b*32 +: 32] |= ps;
      rreg(12'(12'h084 + 32 * b), d); check("R2 mask set", d, mask_m[b*32 +: 32]);
      wreg(12'(12'h088 + 32 * b), 32'hFFFF_FFFF);
      wreg(12'(12'h08C + 32 * b), 32'h0000_0002);
      mask_m[b*32 +: 32] = 32'h2;
      rreg(12'(12'h084 + 32 * b), d); check("R2 final mask", d, 32'h2);
    end

    // R3 pending
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); src = pat(t) | {N{t[0]}};
      for (int b = 0; b < 3; b++) begin
        rreg(12'(12'h098 + 32 * b), d);
        check("R3 pending", d, src[b*32 +: 32] & ~mask_m[b*32 +: 32]);
      end
    end

    // R5 / R7 / R8 arbitration sweeps over thresholds
    for (int k = 0; k < 4; k++) begin
      logic [7:0] tv;
      tv = (k == 0) ? 8'hFF : (k == 1) ? 8'h28 : (k == 2) ? 8'h08 : 8'h00;
      wreg(12'h068, {24'b0, tv}); thr_m = tv;
      for (int t = 0; t < 10; t++)
        set_src_ack_check((k == 0) ? "R5 winner" : "R7 threshold winner", pat(t + k));
    end
    wreg(12'h068, 32'hFF); thr_m = 8'hFF;

    // R5 ties and priority over number
    wreg(12'h100 + 12'(4 * 10), 32'h0C); prio_m[10] = 3;
    wreg(12'h100 + 12'(4 * 20), 32'h0C); prio_m[20] = 3;
    wreg(12'h100 + 12'(4 * 50), 32'h04); prio_m[50] = 1;
    set_src_ack_check("R5 tie lower number", (N'(1) << 10) | (N'(1) << 20));
    set_src_ack_check("R5 lower value wins", (N'(1) << 20) | (N'(1) << 50));
    set_src_ack_check("R5 masked line ignored", (N'(1) << 33));

    // R6 hold until acknowledge
    set_src_ack_check("R6 single line", N'(1) << 95);
    @(negedge clk); src = ~N'(0);
    repeat (3) @(negedge clk);
    rreg(12'h040, d); check("R6 held despite better line", d, 95);
    rreg(12'h040, d); check("R6 read no side effect", d, 95);
    set_src_ack_check("R6 after ack", ~N'(0));

    // R10 stored-only bits
    wreg(12'h010, 32'h1); rreg(12'h010, d); check("R10 autoidle", d, 1);
    wreg(12'h04C, 32'h1); rreg(12'h04C, d); check("R10 protection", d, 1);
    wreg(12'h050, 32'h3); rreg(12'h050, d); check("R10 idle", d, 3);
    set_src_ack_check("R10 no effect on winner", pat(4));

    // R9 soft reset
    wreg(12'h010, 32'h2);
    rreg(12'h010, d); check("R9 config busy bit", d, 2);
    rreg(12'h014, d); check("R9 status during reset", d, 0);
    wreg(12'h088, 32'hFFFF_FFFF);
    repeat (RST + 4) @(negedge clk);
    rreg(12'h014, d); check("R9 status done", d, 1);
    rreg(12'h010, d); check("R9 config cleared", d, 0);
    rreg(12'h084, d); check("R9 write ignored, mask", d, 32'hFFFF_FFFF);
    rreg(12'h0C4, d); check("R9 mask bank2", d, 32'hFFFF_FFFF);
    rreg(12'h100 + 12'(4 * 50), d); check("R9 prio", d, 0);
    rreg(12'h040, d); check("R9 active", d, 0);
    rreg(12'h068, d); check("R9 threshold", d, 32'hFF);
    check("R9 irq_o", {31'b0, irq}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule